// File: doc/BRIEF.md
# Video Memory Byte Copy Engine

This block moves a run of bytes from one place in a byte-addressed video memory to another place in the same memory. A single start pulse captures a byte count, a source pointer, a destination pointer, an access code and a destination stride. The engine then reads one byte and writes one byte in turn through a single-port memory port that has a registered read. The source pointer always steps by one. The destination pointer steps by the stride. Both pointers flip their lowest bit on the way to the memory, so each access lands on the other byte of the same 16-bit word.

Writes that fall inside a sprite-attribute window are also copied into a shadow table. The window is found by a base and a base mask, and the shadow index comes from an index mask. Copying only happens when the copy-enable bit of the access code is set. When the engine finishes, it raises a one-cycle done pulse and presents the advanced pointers, so the caller can write them back into its own pointer registers.

Top module: `vram_span_copier`

## Requirements
- R1: Bytes are copied only when bit 4 of `code_in` is 1. Bits 0 to 3 and bit 5 have no effect. When bit 4 is 0, `mem_we` and `sat_we` stay low for the whole operation.
- R2: Each byte is read at address `src ^ 1`. It is then written, unchanged, at address `dst ^ 1`.
- R3: After each byte, the source pointer grows by 1 and the destination pointer grows by `step_in` (zero-extended). Both wrap modulo 65536.
- R4: A `len_in` of 0 copies 65536 bytes. Any other value copies `len_in` bytes.
- R5: From the done pulse until the next accepted start, `src_final` and `dst_final` hold the advanced pointers. When bit 4 is 0, they hold the captured `src_in` and `dst_in` unchanged.
- R6: When a byte is written at a destination `d` where `(d & sat_bmask) == sat_base`, the same byte is written to the shadow table in that same cycle, at index `(d & sat_imask) ^ 1`. No other cycle raises `sat_we`.
- R7: Timing of a copy of N bytes, counted from the clock edge that samples `start`:
  - Each byte takes one read cycle followed by one write cycle.
  - `done` is high for exactly one cycle, in cycle 2N+1.
  - With bit 4 of `code_in` at 0, `done` is high in cycle 1.
- R8: A start pulse that arrives while an operation is in progress is ignored.
- R9: After reset, `done`, `mem_we`, `sat_we`, `src_final` and `dst_final` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| len_in | input | 16 | Byte count (0 means 65536) |
| src_in | input | 16 | Source byte pointer |
| dst_in | input | 16 | Destination byte pointer |
| code_in | input | 6 | Access code; bit 4 enables the copy |
| step_in | input | 8 | Destination stride per byte |
| sat_base | input | 16 | Sprite-table window base |
| sat_bmask | input | 16 | Mask applied to the destination before the base compare |
| sat_imask | input | 16 | Mask applied to the destination to form the shadow index |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after the address |
| sat_we | output | 1 | Shadow-table write enable |
| sat_idx | output | 16 | Shadow-table index |
| sat_wdata | output | 8 | Shadow-table write data |
| src_final | output | 16 | Advanced source pointer |
| dst_final | output | 16 | Advanced destination pointer |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check, on every cycle:
- a write never happens unless the copy bit was captured, and each write directly follows a read;
- the write address is the destination with its low bit flipped;
- every pointer advance is exactly +1 for the source and +stride for the destination;
- a shadow write always coincides with a RAM write of the same byte;
- `done` never lasts two cycles;
- a start is never taken while the engine is busy.

Only the bench scenarios can show the following:
- the final memory image and shadow-table image after overlapping, wrapping, zero-stride and 65536-byte runs;
- the exact cycle of the done pulse;
- that a start injected mid-run leaves the results untouched.

// File: rtl/vcopy_pkg.sv
package vcopy_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2,
      ST_DONE = 2'd3
   } vc_state_e;
endpackage

// File: rtl/vcopy_seq.sv
module vcopy_seq
   import vcopy_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  logic      go,
   input  logic      last,
   output vc_state_e state_o,
   output logic      load,
   output logic      adv,
   output logic      done
);
   vc_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      load = 1'b0;
      adv  = 1'b0;
      done = 1'b0;
      unique case (st_q)
         ST_IDLE: if (start) begin
            load = 1'b1;
            st_d = go ? ST_RD : ST_DONE;
         end
         ST_RD: st_d = ST_WR;
         ST_WR: begin
            adv  = 1'b1;
            st_d = last ? ST_DONE : ST_RD;
         end
         ST_DONE: begin
            done = 1'b1;
            st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;

   assign state_o = st_q;

   AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE) |-> !load); // R8
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
endmodule

// File: rtl/vcopy_ptr.sv
module vcopy_ptr #(
   parameter int ADDR_W = 16,
   parameter int LEN_W  = 16,
   parameter int STEP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              adv,
   input  logic [ADDR_W-1:0] src_in,
   input  logic [ADDR_W-1:0] dst_in,
   input  logic [LEN_W-1:0]  len_in,
   input  logic [STEP_W-1:0] step_in,
   output logic [ADDR_W-1:0] src_q,
   output logic [ADDR_W-1:0] dst_q,
   output logic              last
);
   localparam int CNT_W = LEN_W + 1;

   logic [CNT_W-1:0]  cnt_q;
   logic [STEP_W-1:0] step_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         dst_q  <= '0;
         cnt_q  <= '0;
         step_q <= '0;
      end else if (load) begin
         src_q  <= src_in;
         dst_q  <= dst_in;
         cnt_q  <= {(len_in == '0), len_in};
         step_q <= step_in;
      end else if (adv) begin
         src_q <= src_q + ADDR_W'(1);
         dst_q <= dst_q + ADDR_W'(step_q);
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign last = (cnt_q == CNT_W'(1));

   AST_SRC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> src_q == $past(src_q) + ADDR_W'(1)); // R3
   AST_DST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> dst_q == $past(dst_q) + ADDR_W'($past(step_q))); // R3
   AST_CNT_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      adv |-> cnt_q != '0); // R4
endmodule

// File: rtl/vcopy_sat.sv
module vcopy_sat #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter bit SAT_EN = 1'b1
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] dst,
   input  logic [DATA_W-1:0] data,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] bmask,
   input  logic [ADDR_W-1:0] imask,
   output logic              sat_we,
   output logic [ADDR_W-1:0] sat_idx,
   output logic [DATA_W-1:0] sat_wdata
);
   generate
      if (SAT_EN) begin : g_snoop
         logic hit;
         assign hit       = ((dst & bmask) == base);
         assign sat_we    = wr_en & hit;
         assign sat_idx   = (dst & imask) ^ ADDR_W'(1);
         assign sat_wdata = data;
      end else begin : g_nosnoop
         logic unused_ok;
         assign unused_ok = &{1'b0, wr_en, dst, data, base, bmask, imask};
         assign sat_we    = 1'b0;
         assign sat_idx   = '0;
         assign sat_wdata = '0;
      end
   endgenerate
endmodule

// File: rtl/vram_span_copier.sv
module vram_span_copier
   import vcopy_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int LEN_W    = 16,
   parameter int CODE_W   = 6,
   parameter int STEP_W   = 8,
   parameter int COPY_BIT = 4,
   parameter bit SAT_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LEN_W-1:0]  len_in,
   input  logic [ADDR_W-1:0] src_in,
   input  logic [ADDR_W-1:0] dst_in,
   input  logic [CODE_W-1:0] code_in,
   input  logic [STEP_W-1:0] step_in,
   input  logic [ADDR_W-1:0] sat_base,
   input  logic [ADDR_W-1:0] sat_bmask,
   input  logic [ADDR_W-1:0] sat_imask,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              sat_we,
   output logic [ADDR_W-1:0] sat_idx,
   output logic [DATA_W-1:0] sat_wdata,
   output logic [ADDR_W-1:0] src_final,
   output logic [ADDR_W-1:0] dst_final,
   output logic              done
);
   localparam logic [CODE_W-1:0] COPY_MASK = CODE_W'(1) << COPY_BIT;

   generate
      if (ADDR_W < 2)          begin : g_chk_a $error("ADDR_W must be at least 2");       end
      if (STEP_W > ADDR_W)     begin : g_chk_s $error("STEP_W must not exceed ADDR_W");   end
      if (COPY_BIT >= CODE_W)  begin : g_chk_c $error("COPY_BIT must lie inside CODE_W"); end
      if (LEN_W < 1)           begin : g_chk_l $error("LEN_W must be at least 1");        end
   endgenerate

   vc_state_e         state;
   logic              load, adv, last, go, copy_q;
   logic [ADDR_W-1:0] src_q, dst_q;

   assign go = |(code_in & COPY_MASK);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)    copy_q <= 1'b0;
      else if (load) copy_q <= go;

   vcopy_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .go      (go),
      .last    (last),
      .state_o (state),
      .load    (load),
      .adv     (adv),
      .done    (done)
   );

   vcopy_ptr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .STEP_W(STEP_W)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .adv     (adv),
      .src_in  (src_in),
      .dst_in  (dst_in),
      .len_in  (len_in),
      .step_in (step_in),
      .src_q   (src_q),
      .dst_q   (dst_q),
      .last    (last)
   );

   assign mem_we    = (state == ST_WR);
   assign mem_addr  = (mem_we ? dst_q : src_q) ^ ADDR_W'(1);
   assign mem_wdata = mem_rdata;
   assign src_final = src_q;
   assign dst_final = dst_q;

   vcopy_sat #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SAT_EN(SAT_EN)) u_sat (
      .wr_en     (mem_we),
      .dst       (dst_q),
      .data      (mem_wdata),
      .base      (sat_base),
      .bmask     (sat_bmask),
      .imask     (sat_imask),
      .sat_we    (sat_we),
      .sat_idx   (sat_idx),
      .sat_wdata (sat_wdata)
   );

   AST_WE_NEEDS_COPY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> copy_q); // R1
   AST_READ_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $past(state) == ST_RD); // R7
   AST_WR_ADDR_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr ^ dst_q) == ADDR_W'(1)); // R2
   AST_SAT_WITH_RAM: assert property (@(posedge clk) disable iff (!rst_n)
      sat_we |-> (mem_we && sat_wdata == mem_wdata)); // R6
endmodule

// File: tb/test_vram_span_copier.sv
module test_vram_span_copier;
   typedef struct packed {
      logic [15:0] len, src, dst;
      logic [5:0]  code;
      logic [7:0]  step;
      logic [15:0] esrc, edst;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{16'd4, 16'h0010, 16'h0100, 6'h10, 8'd1, 16'h0014, 16'h0104},
      '{16'd3, 16'h0021, 16'h0201, 6'h1F, 8'd2, 16'h0024, 16'h0207},
      '{16'd5, 16'hFFFE, 16'hFFFC, 6'h30, 8'd3, 16'h0003, 16'h000B},
      '{16'd2, 16'h0040, 16'h0300, 6'h0F, 8'd1, 16'h0040, 16'h0300},
      '{16'd6, 16'h0080, 16'h0400, 6'h10, 8'd0, 16'h0086, 16'h0400},
      '{16'd4, 16'h0500, 16'h0502, 6'h10, 8'd1, 16'h0504, 16'h0506},
      '{16'd4, 16'h0010, 16'h05FE, 6'h10, 8'd1, 16'h0014, 16'h0602}
   };
   localparam logic [15:0] SBASE = 16'h0600, SBM = 16'hFE00, SIM = 16'h01FF;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [15:0] len_in = '0, src_in = '0, dst_in = '0;
   logic [5:0]  code_in = '0;
   logic [7:0]  step_in = '0;
   logic [15:0] mem_addr, sat_idx, src_final, dst_final;
   logic        mem_we, sat_we, done;
   logic [7:0]  mem_wdata, mem_rdata, sat_wdata;

   logic [7:0] ram [4096];
   logic [7:0] ref_mem [4096];
   logic [7:0] sat_m [512];
   logic [7:0] ref_sat [512];
   int total = 0, bad = 0;

   always #10 clk = ~clk;

   always @(posedge clk) begin
      if (mem_we) ram[mem_addr[11:0]] <= mem_wdata;
      mem_rdata <= ram[mem_addr[11:0]];
      if (sat_we) sat_m[sat_idx[8:0]] <= sat_wdata;
   end

   vram_span_copier i_vram_span_copier (
      .clk(clk), .rst_n(rst_n), .start(start), .len_in(len_in), .src_in(src_in),
      .dst_in(dst_in), .code_in(code_in), .step_in(step_in), .sat_base(SBASE),
      .sat_bmask(SBM), .sat_imask(SIM), .mem_addr(mem_addr), .mem_we(mem_we),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .sat_we(sat_we), .sat_idx(sat_idx),
      .sat_wdata(sat_wdata), .src_final(src_final), .dst_final(dst_final), .done(done)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic run_one(input logic [15:0] l, s, d, input logic [5:0] c,
                          input logic [7:0] st, input logic [15:0] es, ed, input bit poke);
      int n;
      int cyc, wr, addr_bad;
      logic [15:0] ss, ds;
      int mm;
      bit cp;
      n = (l == 16'd0) ? 65536 : int'(l);
      cp = c[4];
      if (cp) begin
         ss = s; ds = d;
         for (int k = 0; k < n; k++) begin
            logic [7:0] b;
            b = ref_mem[12'(ss ^ 16'd1)];
            ref_mem[12'(ds ^ 16'd1)] = b;
            if ((ds & SBM) == SBASE) ref_sat[9'((ds & SIM) ^ 16'd1)] = b;
            ss = ss + 16'd1;
            ds = ds + 16'(st);
         end
      end
      start = 1'b1; len_in = l; src_in = s; dst_in = d; code_in = c; step_in = st;
      @(negedge clk);
      start = 1'b0;
      cyc = 1; wr = 0; addr_bad = 0; ss = s; ds = d;
      while (!done && cyc < 140000) begin
         if (poke && cyc == 2) begin
            start = 1'b1; src_in = 16'hAAAA; dst_in = 16'h5555; len_in = 16'd1;
         end
         if (poke && cyc == 3) start = 1'b0;
         if (mem_we) wr++;
         if (cp && cyc <= 2 * n) begin
            if (cyc % 2 == 1) begin
               if (mem_we || mem_addr != (ss ^ 16'd1)) addr_bad++;
            end else begin
               if (!mem_we || mem_addr != (ds ^ 16'd1)) addr_bad++;
               ss = ss + 16'd1;
               ds = ds + 16'(st);
            end
         end
         @(negedge clk);
         cyc++;
      end
      chk(cyc == (cp ? 2 * n + 1 : 1), "R7 done cycle", cyc, cp ? 2 * n + 1 : 1);
      chk(wr == (cp ? n : 0), "R1/R4 write count", wr, cp ? n : 0);
      chk(addr_bad == 0, "R2 access addresses", addr_bad, 0);
      chk(src_final == es, "R3/R5 src_final", src_final, es);
      chk(dst_final == ed, "R3/R5 dst_final", dst_final, ed);
      mm = 0;
      for (int i = 0; i < 4096; i++) if (ram[i] !== ref_mem[i]) mm++;
      chk(mm == 0, "R2 memory image", mm, 0);
      mm = 0;
      for (int i = 0; i < 512; i++) if (sat_m[i] !== ref_sat[i]) mm++;
      chk(mm == 0, "R6 shadow image", mm, 0);
      @(negedge clk);
      chk(!done, "R7 done single cycle", done, 0);
      chk(src_final == es && dst_final == ed, "R5 pointers held", src_final, es);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) begin
         ram[i] = 8'(i * 7 + 3) ^ 8'(i >> 8);
         ref_mem[i] = ram[i];
      end
      for (int i = 0; i < 512; i++) begin
         sat_m[i] = 8'h00;
         ref_sat[i] = 8'h00;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(!done && !mem_we && !sat_we, "R9 reset outputs", {done, mem_we, sat_we}, 0);
      chk(src_final == 16'd0 && dst_final == 16'd0, "R9 reset pointers", src_final, 0);
      for (int i = 0; i < NV; i++)
         run_one(VECS[i].len, VECS[i].src, VECS[i].dst, VECS[i].code, VECS[i].step,
                 VECS[i].esrc, VECS[i].edst, 1'b0);
      // R1: bit 5 set, bit 4 clear -> no copy, pointers unchanged
      run_one(16'd7, 16'h0123, 16'h0456, 6'h2F, 8'd2, 16'h0123, 16'h0456, 1'b0);
      // R8: start pulse injected mid-run is ignored
      run_one(16'd5, 16'h0700, 16'h0800, 6'h10, 8'd2, 16'h0705, 16'h080A, 1'b1);
      // R4: length 0 copies 65536 bytes, pointers wrap back
      run_one(16'd0, 16'h0123, 16'h0777, 6'h10, 8'd2, 16'h0123, 16'h0777, 1'b0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule